// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast reference clock into the 16x oversampling strobe that a serial transmitter and receiver step on. The ratio is given as a 16-bit whole part and a 6-bit fraction in units of 1/64. The whole part sets the base number of reference clocks between strobes. The fraction is collected in a small phase accumulator, and each time that accumulator wraps, one gap is stretched by a single reference clock. Over 64 strobes the average gap therefore equals the programmed ratio exactly. The ratio to program is the reference frequency divided by sixteen times the wanted line rate.

The divisor inputs pass through a hold register that copies them only while the serial engines report an idle line. A divisor changed in the middle of a character therefore takes effect only after that character ends, so no frame is sent or sampled at two rates. A whole part of zero, or a whole part of all ones together with a nonzero fraction, cannot be realised. Either one raises an invalid flag and stops the strobe. Dropping the enable stops the strobe and clears both the gap counter and the phase accumulator, so that each enable starts from a known phase.

Top module: `frac_baud_gen`

## Requirements
- R1: Reset clears the held divisor to zero. While reset is high and after it is released, `tick` is 0 and `div_invalid` is 1 until a valid divisor is held.
- R2: With fraction 0 and whole part N (1 to 65535), `tick` is a pulse of one clock that repeats every N clocks. With N = 1 it is high on every clock.
- R3: With whole part N and fraction F, the gap that follows the k-th strobe after enable (k counted from 0) is N+1 clocks when the 6-bit sum of F added k+1 times from zero carries out on its last addition, and N clocks otherwise. Any 64 gaps counted from enable therefore add up to 64*N+F clocks.
- R4: A held whole part of 0 sets `div_invalid` to 1 one clock after it is presented with the line idle, and no `tick` occurs while that divisor is held.
- R5: A held whole part of 0xFFFF with a nonzero fraction sets `div_invalid` and stops `tick`. A whole part of 0xFFFF with fraction 0 is valid.
- R6: Divisor inputs are copied into the hold register on every clock on which `line_busy` is 0. While `line_busy` is 1, changes to them have no effect on `tick` or `div_invalid`. After release, the gap in progress finishes with the old count, and later gaps use the new divisor.
- R7: While `enable` is 0, `tick` stays 0 and the gap counter and the accumulator are cleared. The first strobe is output one clock after the first clock edge that samples `enable` at 1 with a valid divisor, and the fraction sequence of R3 restarts from a zero accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the generator. When 0, the counter and the accumulator are cleared |
| line_busy | input | 1 | A character is in flight on the transmit or receive side. Freezes the held divisor |
| div_whole | input | 16 | Whole part of the divisor |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 steps |
| tick | output | 1 | Oversampling strobe, one clock wide |
| div_invalid | output | 1 | The held divisor cannot be realised |

## Verification
The bench measures every gap between strobes for many random whole and fractional values. It checks each gap against the carry sequence of the accumulator and checks the 64-gap total, so a design that stretches the gap one strobe late, or that lets the accumulator drift across an enable, shows up as a gap that lands in the wrong place. The corner cases are N = 1 with fraction 0 (a strobe stuck high or skipping a clock would be caught) and N = 1 with fraction 63 (gaps of 2 almost everywhere). The two illegal encodings must silence the strobe, while 0xFFFF with a zero fraction must stay legal. A divisor changed while the line is busy must neither alter the gaps nor raise the flag, so a design that copies the divisor at the wrong time shows gaps of the wrong length right after the change.

// File: rtl/frac_baud_pkg.sv
`timescale 1ns/1ps
package frac_baud_pkg;

    localparam int DEF_WHOLE_W = 16;
    localparam int DEF_FRAC_W  = 6;

    typedef enum logic [1:0] {
        GEN_OFF = 2'd0,
        GEN_BAD = 2'd1,
        GEN_RUN = 2'd2
    } gen_mode_e;

    function automatic gen_mode_e fbg_mode(input logic en, input logic bad);
        if (!en)
            return GEN_OFF;
        else if (bad)
            return GEN_BAD;
        return GEN_RUN;
    endfunction

endpackage

// File: rtl/fbg_divisor_hold.sv
`timescale 1ns/1ps
module fbg_divisor_hold #(
    parameter int WHOLE_W = 16,
    parameter int FRAC_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_busy,
    input  logic [WHOLE_W-1:0] whole_in,
    input  logic [FRAC_W-1:0]  frac_in,
    output logic [WHOLE_W-1:0] whole_q,
    output logic [FRAC_W-1:0]  frac_q,
    output logic               bad
);
    always_ff @(posedge clk) begin
        if (rst) begin
            whole_q <= '0;
            frac_q  <= '0;
        end else if (!line_busy) begin
            whole_q <= whole_in;
            frac_q  <= frac_in;
        end
    end

    // zero whole part, or top whole part that a fraction would push past range
    always_comb begin
        bad = (whole_q == '0) || ((&whole_q) && (frac_q != '0));
    end
endmodule

// File: rtl/fbg_phase_acc.sv
`timescale 1ns/1ps
module fbg_phase_acc #(
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry,
    output logic [FRAC_W-1:0] acc_q
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (step)
            acc_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/fbg_period_count.sv
`timescale 1ns/1ps
module fbg_period_count #(
    parameter int WHOLE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [WHOLE_W-1:0] whole,
    input  logic               stretch,
    output logic               wrap,
    output logic               tick
);
    logic [WHOLE_W-1:0] cnt;
    logic [WHOLE_W-1:0] reload;

    always_comb begin
        wrap   = (cnt == '0);
        reload = whole - WHOLE_W'(1) + WHOLE_W'(stretch);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= wrap;
            if (wrap)
                cnt <= reload;
            else
                cnt <= cnt - WHOLE_W'(1);
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int WHOLE_W = DEF_WHOLE_W,
    parameter int FRAC_W  = DEF_FRAC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               line_busy,
    input  logic [WHOLE_W-1:0] div_whole,
    input  logic [FRAC_W-1:0]  div_frac,
    output logic               tick,
    output logic               div_invalid
);
    logic [WHOLE_W-1:0] held_whole;
    logic [FRAC_W-1:0]  held_frac;
    logic [FRAC_W-1:0]  acc_q;
    logic               bad;
    logic               carry;
    logic               wrap;
    logic               run;
    gen_mode_e          mode;

    fbg_divisor_hold #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .line_busy (line_busy),
        .whole_in  (div_whole),
        .frac_in   (div_frac),
        .whole_q   (held_whole),
        .frac_q    (held_frac),
        .bad       (bad)
    );

    always_comb begin
        mode        = fbg_mode(enable, bad);
        run         = (mode == GEN_RUN);
        div_invalid = bad;
    end

    fbg_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (!run),
        .step  (run && wrap),
        .frac  (held_frac),
        .carry (carry),
        .acc_q (acc_q)
    );

    fbg_period_count #(.WHOLE_W(WHOLE_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (!run),
        .whole   (held_whole),
        .stretch (carry),
        .wrap    (wrap),
        .tick    (tick)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
`timescale 1ns/1ps
module frac_baud_gen_chk #(
    parameter int WHOLE_W = 16,
    parameter int FRAC_W  = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               line_busy,
    input logic [WHOLE_W-1:0] div_whole,
    input logic [FRAC_W-1:0]  div_frac,
    input logic               tick,
    input logic               div_invalid,
    input logic [WHOLE_W-1:0] held_whole,
    input logic [FRAC_W-1:0]  acc_q,
    input logic               run,
    input logic               wrap
);
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !tick);

    p_quiet_when_bad_r4: assert property (@(posedge clk) disable iff (rst)
        div_invalid |=> !tick);

    p_hold_while_busy_r6: assert property (@(posedge clk) disable iff (rst)
        line_busy |=> $stable(held_whole));

    p_acc_only_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(acc_q));

    p_zero_whole_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (!line_busy && div_whole == '0) |=> div_invalid);

    p_top_whole_frac_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (!line_busy && (&div_whole) && div_frac != '0) |=> div_invalid);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .line_busy   (line_busy),
    .div_whole   (div_whole),
    .div_frac    (div_frac),
    .tick        (tick),
    .div_invalid (div_invalid),
    .held_whole  (held_whole),
    .acc_q       (acc_q),
    .run         (run),
    .wrap        (wrap)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic        line_busy;
    logic [15:0] div_whole;
    logic [5:0]  div_frac;
    logic        tick;
    logic        div_invalid;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;
    int times [0:79];
    int got;

    frac_baud_gen uut (
        .clk(clk), .rst(rst), .enable(enable), .line_busy(line_busy),
        .div_whole(div_whole), .div_frac(div_frac),
        .tick(tick), .div_invalid(div_invalid)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // gap after strobe k, from the accumulator rule of R3
    function automatic int exp_gap(input int n, input int f, input int k);
        int acc = 0;
        int c = 0;
        for (int j = 0; j <= k; j++) begin
            c   = (acc + f) >> 6;
            acc = (acc + f) & 63;
        end
        return n + c;
    endfunction

    task automatic grab(input int want, input int limit);
        got = 0;
        for (int i = 0; i < limit && got < want; i++) begin
            @(negedge clk);
            if (tick) begin
                times[got] = cyc;
                got++;
            end
        end
    endtask

    task automatic run_case(input int n, input int f, input int gaps, input string req);
        int c0;
        @(negedge clk);
        enable = 0; line_busy = 0; div_whole = 16'(n); div_frac = 6'(f);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tick == 0, "R7 quiet while disabled", tick, 0);
        end
        enable = 1;
        c0 = cyc;
        grab(gaps + 1, (n + 2) * (gaps + 3));
        check(got == gaps + 1, req, got, gaps + 1);
        check(times[0] == c0 + 1, "R7 first strobe after enable", times[0] - c0, 1);
        for (int k = 0; k < gaps && k + 1 < got; k++)
            check(times[k+1] - times[k] == exp_gap(n, f, k), req,
                  times[k+1] - times[k], exp_gap(n, f, k));
        if (gaps == 64 && got == 65)
            check(times[64] - times[0] == 64 * n + f, "R3 64-gap total",
                  times[64] - times[0], 64 * n + f);
    endtask

    task automatic count_quiet(input int cycles, input string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3a));
        rst = 1; enable = 0; line_busy = 0; div_whole = 0; div_frac = 0;
        repeat (3) @(negedge clk);
        check(tick == 0, "R1 tick in reset", tick, 0);
        check(div_invalid == 1, "R1 flag in reset", div_invalid, 1);
        rst = 0;
        @(negedge clk);
        check(div_invalid == 1, "R1 flag after reset", div_invalid, 1);

        // R2 integer-only divisors
        run_case(1, 0, 20, "R2 gap N=1");
        run_case(4, 0, 10, "R2 gap N=4");
        run_case(13, 0, 8, "R2 gap N=13");
        // R3 fractional corners
        run_case(1, 63, 64, "R3 gap N=1 F=63");
        run_case(2, 1, 64, "R3 gap N=2 F=1");
        run_case(3, 32, 64, "R3 gap N=3 F=32");
        for (int r = 0; r < 12; r++) begin
            int n = 1 + int'($urandom % 40);
            int f = int'($urandom % 64);
            run_case(n, f, 64, "R3 random gap");
        end

        // R4 zero whole part
        @(negedge clk);
        enable = 1; line_busy = 0; div_whole = 0; div_frac = 7;
        repeat (2) @(negedge clk);
        check(div_invalid == 1, "R4 flag on zero", div_invalid, 1);
        count_quiet(100, "R4 no strobe on zero");

        // R5 top whole part
        div_whole = 16'hFFFF; div_frac = 5;
        repeat (2) @(negedge clk);
        check(div_invalid == 1, "R5 flag on FFFF+frac", div_invalid, 1);
        count_quiet(100, "R5 no strobe on FFFF+frac");
        div_frac = 0;
        repeat (2) @(negedge clk);
        check(div_invalid == 0, "R5 FFFF with zero frac legal", div_invalid, 0);

        // R6 hold while busy
        run_case(5, 0, 3, "R6 setup");
        line_busy = 1; div_whole = 9;
        grab(5, 60);
        for (int k = 0; k < 4; k++)
            check(times[k+1] - times[k] == 5, "R6 old gap while busy", times[k+1] - times[k], 5);
        div_whole = 0;
        repeat (3) @(negedge clk);
        check(div_invalid == 0, "R6 busy hides zero", div_invalid, 0);
        grab(3, 30);
        check(times[2] - times[1] == 5, "R6 gap kept with zero while busy", times[2] - times[1], 5);
        div_whole = 9;
        line_busy = 0;
        grab(5, 80);
        for (int k = 1; k < 4; k++)
            check(times[k+1] - times[k] == 9, "R6 new gap after release", times[k+1] - times[k], 9);

        // R7 disable mid-run, then restart phase
        run_case(7, 40, 5, "R7 setup");
        @(negedge clk);
        enable = 0;
        count_quiet(40, "R7 no strobe while disabled");
        run_case(7, 40, 64, "R7 restart phase");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule